// File: doc/BRIEF.md
# Two-Output PWM Action Qualifier with Continuous Software Force

This block turns the state of an external time-base counter into two PWM levels. Each clock in which the time-base tick enable is high, it looks at four events: the counter at zero, the counter at period, the counter equal to compare register A while counting up, and the counter equal to compare register B while counting up. For each output, a per-output action word gives every event a 2-bit code. The code either leaves the level alone, drives it low, drives it high or toggles it. When several events fall on the same tick, a fixed priority decides which one acts.

On top of the qualified level sits a continuous software force. Software writes a shadow force register. That register holds a force code for each output and a 2-bit reload selector. The selector decides when the shadow value is copied into the active force: at zero, at period, at either of them, or on the very next clock. An active force pins its output high or low for as long as it stays in effect. The action logic keeps running underneath, so the output resumes the tracked level as soon as the force is removed.

Configuration goes through a small write port: two 16-bit compare registers, two action words and the shadow force register. Counter generation is outside this block.

Top module: `pwmaq_top`

## Requirements
- R1: While rst_n is low, and just after it is released, both outputs are low, both action words and both compare registers are zero, and both force fields are disabled with the reload selector at 00.
- R2: Each 2-bit action code acts on the output level as follows: 00 keeps it, 01 sets it low, 10 sets it high, 11 inverts it.
- R3: In an action word, bits [1:0] belong to the zero event, [3:2] to the period event, [5:4] to the compare-A up-count match and [9:8] to the compare-B up-count match. Both outputs see all four events; a compare match is counter equal to the compare register while cnt_up is 1.
- R4: Events act only in a clock where tb_en is 1. The new level is visible on the output right after that rising edge. With tb_en low, the qualified level does not change.
- R5: Among the events present on one tick whose code is not 00, the one that acts is chosen in the order compare B, compare A, period, zero (highest first).
- R6: The action word 0x01A with a compare value C gives a high output from zero up to the C match and a low output after it; the word 0x205 gives the inverted waveform.
- R7: Force bits [1:0] control output A and bits [3:2] control output B. Code 01 forces low, 10 forces high, 00 and 11 leave the qualified level on the output. An active force overrides the level for as long as it is in effect.
- R8: Shadow force bits [7:6] select the reload point: 00 at a zero event, 01 at a period event, 10 at either. Both of these events count only when tb_en is 1. Between reload points the active force does not change.
- R9: With reload selector 11, the shadow value becomes active at the rising edge that follows the write edge, whatever tb_en is, so the forced level appears one clock after the write.
- R10: A write with wr_en high stores wr_data at the rising edge, by wr_addr: 0 compare A, 1 compare B, 2 action word A (bits [9:0]), 3 action word B (bits [9:0]), 4 shadow force (bits [7:0]). Events on the same edge still use the old register contents.
- R11: While cnt_up is 0, compare equality produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | Time-base tick enable qualifying all events |
| cnt | input | 16 | Time-base counter value |
| cnt_up | input | 1 | 1 while the counter counts up |
| zero_evt | input | 1 | Counter-at-zero strobe |
| prd_evt | input | 1 | Counter-at-period strobe |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register select |
| wr_data | input | 16 | Configuration write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The embedded properties watch every cycle for these rules:
- the qualified level holds while tb_en is low;
- a compare-B low code wins over everything else;
- a lone zero-high event sets the level;
- immediate reload copies the shadow value one clock later;
- zero-mode reload leaves the active force alone between zero events;
- an active force pins the pin level.

Other behaviours can only be shown by the bench's scenarios, where a behavioural model runs alongside the design and is compared every clock. These are the full waveforms of normal and inverted polarity, toggling, coincident events with compare values at zero, the absence of compare events while counting down, the period and either-event reload modes, and a reset in mid-run.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;
  localparam int CNT_W  = 16;
  localparam int ACT_W  = 10;
  localparam int SHD_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_code_e;

  typedef enum logic [1:0] {
    RLD_AT_ZERO = 2'b00,
    RLD_AT_PRD  = 2'b01,
    RLD_AT_BOTH = 2'b10,
    RLD_NOW     = 2'b11
  } reload_e;

  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ACTA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ACTB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FORCE = 3'd4;

  function automatic logic apply_code(input logic [1:0] code, input logic cur);
    case (code)
      ACT_LOW:  apply_code = 1'b0;
      ACT_HIGH: apply_code = 1'b1;
      ACT_FLIP: apply_code = ~cur;
      default:  apply_code = cur;
    endcase
  endfunction

  function automatic logic force_level(input logic [1:0] frc, input logic lvl);
    case (frc)
      2'b01:   force_level = 1'b0;
      2'b10:   force_level = 1'b1;
      default: force_level = lvl;
    endcase
  endfunction
endpackage

// File: rtl/pwmaq_evt.sv
module pwmaq_evt
  import pwmaq_pkg::*;
#(
  parameter int W    = CNT_W,
  parameter int NCMP = 2
) (
  input  logic [W-1:0]         cnt,
  input  logic                 cnt_up,
  input  logic                 tb_en,
  input  logic                 zero_in,
  input  logic                 prd_in,
  input  logic [NCMP-1:0][W-1:0] cmp,
  output logic                 ev_zero,
  output logic                 ev_prd,
  output logic [NCMP-1:0]      ev_cmp
);
  assign ev_zero = tb_en & zero_in;
  assign ev_prd  = tb_en & prd_in;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign ev_cmp[g] = tb_en & cnt_up & (cnt == cmp[g]);
  end
endmodule

// File: rtl/pwmaq_chan.sv
module pwmaq_chan
  import pwmaq_pkg::*;
#(
  parameter int AW = ACT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_en,
  input  logic          ev_zero,
  input  logic          ev_prd,
  input  logic          ev_ca,
  input  logic          ev_cb,
  input  logic [AW-1:0] act_word,
  output logic          lvl
);
  logic       lvl_q, lvl_d;
  logic [1:0] sel_code;

  // lowest priority first, later lines override (R5)
  always_comb begin
    sel_code = ACT_KEEP;
    if (ev_zero && act_word[1:0] != 2'b00) sel_code = act_word[1:0];
    if (ev_prd  && act_word[3:2] != 2'b00) sel_code = act_word[3:2];
    if (ev_ca   && act_word[5:4] != 2'b00) sel_code = act_word[5:4];
    if (ev_cb   && act_word[9:8] != 2'b00) sel_code = act_word[9:8];
  end

  always_comb begin
    lvl_d = lvl_q;
    if (tb_en) lvl_d = apply_code(sel_code, lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign lvl = lvl_q;

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> $stable(lvl_q));
  p_cmpb_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && ev_cb && act_word[9:8] == 2'b01) |=> !lvl_q);
  p_zero_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && ev_zero && !ev_prd && !ev_ca && !ev_cb && act_word[1:0] == 2'b10) |=> lvl_q);
endmodule

// File: rtl/pwmaq_force.sv
module pwmaq_force
  import pwmaq_pkg::*;
#(
  parameter int SW = SHD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_en,
  input  logic          zero_in,
  input  logic          prd_in,
  input  logic          wr,
  input  logic [SW-1:0] wdata,
  output logic [3:0]    frc_act
);
  logic [SW-1:0] sh_q, sh_d;
  logic [3:0]    act_q, act_d;
  logic          load;
  reload_e       mode;

  assign mode = reload_e'(sh_q[7:6]);

  always_comb begin
    case (mode)
      RLD_AT_ZERO: load = tb_en & zero_in;
      RLD_AT_PRD:  load = tb_en & prd_in;
      RLD_AT_BOTH: load = tb_en & (zero_in | prd_in);
      default:     load = 1'b1;
    endcase
    act_d = load ? sh_q[3:0] : act_q;
    sh_d  = wr ? wdata : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign frc_act = act_q;

  p_now_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_q[7:6] == 2'b11) |=> act_q == $past(sh_q[3:0]));
  p_zero_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_q[7:6] == 2'b00 && !(tb_en && zero_in)) |=> $stable(act_q));
endmodule

// File: rtl/pwmaq_top.sv
module pwmaq_top
  import pwmaq_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ACT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic [W-1:0]      cnt,
  input  logic              cnt_up,
  input  logic              zero_evt,
  input  logic              prd_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NCH = 2;

  logic [NCH-1:0][W-1:0]  cmp_q, cmp_d;
  logic [NCH-1:0][AW-1:0] act_q, act_d;
  logic                   ev_zero, ev_prd;
  logic [NCH-1:0]         ev_cmp;
  logic [NCH-1:0]         lvl;
  logic [3:0]             frc_act;

  always_comb begin
    cmp_d = cmp_q;
    act_d = act_q;
    if (wr_en) begin
      case (wr_addr)
        A_CMPA: cmp_d[0] = wr_data[W-1:0];
        A_CMPB: cmp_d[1] = wr_data[W-1:0];
        A_ACTA: act_d[0] = wr_data[AW-1:0];
        A_ACTB: act_d[1] = wr_data[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      act_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      act_q <= act_d;
    end
  end

  pwmaq_evt #(.W(W), .NCMP(NCH)) u_evt (
    .cnt(cnt), .cnt_up(cnt_up), .tb_en(tb_en), .zero_in(zero_evt),
    .prd_in(prd_evt), .cmp(cmp_q), .ev_zero(ev_zero), .ev_prd(ev_prd),
    .ev_cmp(ev_cmp)
  );

  pwmaq_force #(.SW(SHD_W)) u_force (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .zero_in(zero_evt),
    .prd_in(prd_evt), .wr(wr_en && wr_addr == A_FORCE),
    .wdata(wr_data[SHD_W-1:0]), .frc_act(frc_act)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmaq_chan #(.AW(AW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .ev_zero(ev_zero),
      .ev_prd(ev_prd), .ev_ca(ev_cmp[0]), .ev_cb(ev_cmp[1]),
      .act_word(act_q[g]), .lvl(lvl[g])
    );
  end

  assign pwm_a = force_level(frc_act[1:0], lvl[0]);
  assign pwm_b = force_level(frc_act[3:2], lvl[1]);

  p_force_low_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[1:0] == 2'b01) |-> !pwm_a);
  p_force_high_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[3:2] == 2'b10) |-> pwm_b);
endmodule

// File: tb/pwmaq_top_tb_top.sv
module pwmaq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_en = 1'b0;
  logic [15:0] cnt = '0;
  logic        cnt_up = 1'b1;
  logic        zero_evt = 1'b0;
  logic        prd_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";
  int P = 20;
  int c_next = 0;
  bit dir_up = 1'b1;

  // reference model state
  int m_cmp[2];
  int m_act[2];
  int m_sh;
  int m_fa;
  bit m_lvl[2];

  always #2 clk = ~clk;  // 250 MHz

  pwmaq_top dut_i (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .cnt(cnt), .cnt_up(cnt_up),
    .zero_evt(zero_evt), .prd_evt(prd_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic bit fld(int w, int pos);
    return 1'b0;
  endfunction

  function automatic int code_of(int w, int pos);
    return (w >> pos) & 3;
  endfunction

  function automatic bit model_out(int fcode, bit l);
    if (fcode == 1) return 1'b0;
    if (fcode == 2) return 1'b1;
    return l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = '{0, 0}; m_act = '{0, 0}; m_sh = 0; m_fa = 0; m_lvl = '{0, 0};
    end else begin
      bit ez, ep, eca, ecb, ld;
      bit nl[2];
      int nfa, mode;
      ez  = tb_en && zero_evt;
      ep  = tb_en && prd_evt;
      eca = tb_en && cnt_up && (int'(cnt) == m_cmp[0]);
      ecb = tb_en && cnt_up && (int'(cnt) == m_cmp[1]);
      for (int ch = 0; ch < 2; ch++) begin
        int code;
        code = 0;
        if (ecb && code_of(m_act[ch], 8) != 0)      code = code_of(m_act[ch], 8);
        else if (eca && code_of(m_act[ch], 4) != 0) code = code_of(m_act[ch], 4);
        else if (ep && code_of(m_act[ch], 2) != 0)  code = code_of(m_act[ch], 2);
        else if (ez && code_of(m_act[ch], 0) != 0)  code = code_of(m_act[ch], 0);
        nl[ch] = m_lvl[ch];
        if (tb_en) begin
          if (code == 1) nl[ch] = 1'b0;
          else if (code == 2) nl[ch] = 1'b1;
          else if (code == 3) nl[ch] = !m_lvl[ch];
        end
      end
      mode = (m_sh >> 6) & 3;
      ld = (mode == 3) || (mode == 0 && ez) || (mode == 1 && ep) || (mode == 2 && (ez || ep));
      nfa = ld ? (m_sh & 15) : m_fa;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_cmp[0] = int'(wr_data);
          3'd1: m_cmp[1] = int'(wr_data);
          3'd2: m_act[0] = int'(wr_data) & 10'h3FF;
          3'd3: m_act[1] = int'(wr_data) & 10'h3FF;
          3'd4: m_sh = int'(wr_data) & 8'hFF;
          default: ;
        endcase
      end
      m_lvl = nl;
      m_fa = nfa;
    end
  end

  task automatic check(string req, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, pwm_a, model_out(m_fa & 3, m_lvl[0]), "pwm_a vs model");
      check(cur_req, pwm_b, model_out((m_fa >> 2) & 3, m_lvl[1]), "pwm_b vs model");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(bit en);
    @(negedge clk); #1;
    tb_en    = en;
    cnt      = 16'(c_next);
    cnt_up   = dir_up;
    zero_evt = (c_next == 0);
    prd_evt  = (c_next == P);
    if (en) begin
      if (dir_up) c_next = (c_next == P) ? 0 : c_next + 1;
      else        c_next = (c_next == 0) ? P : c_next - 1;
    end
  endtask

  task automatic run(int n, int en_every);
    for (int i = 0; i < n; i++) step((i % en_every) == 0);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1'b1);
    @(negedge clk); #1;
    wr_en = 1'b0;
    c_next = c_next;
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1", pwm_a, 1'b0, "pwm_a in reset");
    check("R1", pwm_b, 1'b0, "pwm_b in reset");
    @(negedge clk); #1; rst_n = 1'b1;
    run(30, 1);
    check("R1", pwm_a, 1'b0, "pwm_a after reset, actions cleared");

    // R10/R6: normal polarity on A, inverted on B
    cur_req = "R6";
    wr(3'd0, 16'd5);
    wr(3'd1, 16'd12);
    wr(3'd2, 16'h01A);
    wr(3'd3, 16'h205);
    run(70, 1);
    c_next = 0; step(1); step(1);
    @(negedge clk);
    check("R6", pwm_a, 1'b1, "A high just after zero");
    check("R6", pwm_b, 1'b0, "B low just after zero (inverted)");
    run(60, 1);

    // R2/R3: toggle on zero and period for A, B toggles on compare A
    cur_req = "R2";
    wr(3'd2, 16'h00F);
    wr(3'd3, 16'h030);
    run(90, 1);

    // R5: coincident events, compares at zero
    cur_req = "R5";
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'h212);
    wr(3'd3, 16'h112);
    run(70, 1);

    // R4: sparse tick enable
    cur_req = "R4";
    wr(3'd0, 16'd4);
    wr(3'd1, 16'd9);
    wr(3'd2, 16'h01A);
    wr(3'd3, 16'h306);
    run(150, 3);

    // R11: counting down, compare toggles must not fire
    cur_req = "R11";
    wr(3'd2, 16'h030);
    wr(3'd3, 16'h300);
    dir_up = 1'b0;
    run(80, 1);
    dir_up = 1'b1;

    // R8: reload points for the force
    cur_req = "R8";
    wr(3'd2, 16'h01A);
    wr(3'd3, 16'h205);
    wr(3'd4, 16'h002);
    run(50, 1);
    check("R8", pwm_a, 1'b1, "A forced high after zero reload");
    wr(3'd4, 16'h044);
    run(50, 2);
    wr(3'd4, 16'h083);
    run(50, 1);

    // R9/R7: immediate reload
    cur_req = "R9";
    tb_en = 1'b0;
    wr(3'd4, 16'h0C8);
    step(1'b0);
    @(negedge clk);
    check("R9", pwm_b, 1'b1, "B forced high one clock after write");
    cur_req = "R7";
    run(60, 1);
    check("R7", pwm_b, 1'b1, "B stays forced high across period");
    wr(3'd4, 16'h0C1);
    run(40, 1);
    check("R7", pwm_a, 1'b0, "A forced low");
    wr(3'd4, 16'h0CF);
    run(40, 1);

    // R1: reset in mid-run
    cur_req = "R1";
    @(negedge clk); #1; rst_n = 1'b0;
    @(negedge clk);
    check("R1", pwm_a, 1'b0, "pwm_a mid-run reset");
    check("R1", pwm_b, 1'b0, "pwm_b mid-run reset");
    #1; rst_n = 1'b1;
    run(45, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule